// File: doc/BRIEF.md
# Phase-Accumulator Clock Synthesizer with Power-of-Two Output Divider

This core builds a digital clock of adjustable frequency from two clocks. In the first section, a wide phase accumulator runs on a fast reference clock and adds a tuning word on every cycle. The top bit of the accumulator is brought out as a square wave. Its average frequency is the tuning word times the reference frequency, divided by 2^32. When the tuning word does not divide 2^32 evenly, individual periods differ by one reference cycle.

In the second section, a free-running binary counter runs on a separate divider clock. In a full system that clock comes from an external multiplier that follows the accumulator output. A 5-bit scale selector picks one counter bit as the final output, so the output is the divider clock divided by 2^(D+1). A change of the selector is applied only when the current output period ends. At that point the counter restarts from zero, so no shortened pulse can appear.

Both control words can be tied to constants to give a fixed-frequency build. One synchronous reset, sampled in each clock domain, clears both sections.

Top module: `dds_clkgen`

## Requirements
- R1: Each fast-clock edge out of reset adds the registered tuning word to the 32-bit accumulator, modulo 2^32. The tuning word is captured one fast edge before it is first added. `synth_msb` equals accumulator bit 31.
- R2: With tuning word 0x10000000, every period of `synth_msb` lasts exactly 16 fast cycles, with 8 of them high.
- R3: With tuning word 0x08000000, every period of `synth_msb` lasts exactly 32 fast cycles, with 16 of them high.
- R4: With tuning word 0x0FE353F7, every period of `synth_msb` lasts 16 or 17 fast cycles. Among 200 consecutive periods, between 21 and 24 last 17 cycles.
- R5: With a steady selector value D, `clk_out` is high for 2^D divider cycles and low for 2^D divider cycles, a period of 2^(D+1).
- R6: A new selector value takes effect only at the end of a high phase of the current output. The counter then restarts at zero, so every high or low run has the length of either the old setting or the new one. At most three runs at the old setting follow the change.
- R7: While `rst` is high at a clock edge, the accumulator, the captured tuning word, the counter and `clk_out` are cleared, so both outputs read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Reference clock of the phase accumulator |
| clk_div | input | 1 | Clock of the power-of-two divider |
| rst | input | 1 | Synchronous reset, active high, sampled in both domains |
| tune_word | input | 32 | Phase increment added per fast cycle |
| scale_sel | input | 5 | Divider tap select D, divide ratio 2^(D+1) |
| synth_msb | output | 1 | Accumulator bit 31, the synthesized square wave |
| clk_out | output | 1 | Selected counter bit, the divided output |

## Verification
The accumulator is tested in two ways. First, a cycle-exact arithmetic model runs against it while the tuning word changes among values that are even divisions of 2^32, extreme values (0, 0x80000000, all ones) and irregular values. Second, period lengths are measured: the even divisions must show fixed periods with no variation, while 0x0FE353F7 must mix 16- and 17-cycle periods at the expected ratio.

The divider is tested with every selector value from 0 to 5, which confirms both the doubling of run length and the 50% duty cycle. Selector changes are tested in both directions, upward and downward. These tests separate a correct switch at a period boundary from one that cuts a run short or switches too late. A reset in the middle of operation confirms that both domains clear.

// File: rtl/dds_pkg.sv
package dds_pkg;
    // Default widths shared by the accumulator and the divider
    localparam int unsigned PHASE_W = 32;
    localparam int unsigned DIVCNT_W = 32;
    localparam int unsigned TAPSEL_W = 5;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int unsigned ACC_W = dds_pkg::PHASE_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] tune_i,
    output logic             msb_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] tune;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.acc  = st_q.acc + st_q.tune;
        st_d.tune = tune_i;
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign msb_o = st_q.acc[ACC_W-1];

    // R1
    acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_i) |=> (st_q.acc == $past(st_q.acc) + $past(st_q.tune)));

    // R7
    acc_rst_chk: assert property (@(posedge clk_i)
        rst_i |=> (st_q.acc == '0 && st_q.tune == '0 && !msb_o));
endmodule

// File: rtl/dds_tap_div.sv
module dds_tap_div #(
    parameter int unsigned CNT_W = dds_pkg::DIVCNT_W,
    parameter int unsigned SEL_W = dds_pkg::TAPSEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             out_o
);
    localparam int unsigned TAPS = 1 << SEL_W;

    initial begin
        if (TAPS > CNT_W) $error("selector reaches beyond counter width");
    end

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] pend;
        logic             out;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] span_mask;
    logic             period_end;

    // bits [sel:0] of the counter span one full output period
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            span_mask[i] = (i <= int'(st_q.sel));
        end
    end

    assign period_end = &(st_q.cnt | ~span_mask);

    always_comb begin
        st_d      = st_q;
        st_d.pend = sel_i;
        if (period_end && (st_q.pend != st_q.sel)) begin
            st_d.cnt = '0;
            st_d.sel = st_q.pend;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.out = st_d.cnt[st_d.sel];
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R5
    out_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.out) |-> ((st_q.cnt & (span_mask >> 1)) == '0));

    // R6
    sel_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.sel != $past(st_q.sel)) |-> (st_q.cnt == '0 && !st_q.out));

    // R7
    div_rst_chk: assert property (@(posedge clk_i)
        rst_i |=> (st_q.cnt == '0 && !st_q.out));
endmodule

// File: rtl/dds_clkgen.sv
module dds_clkgen #(
    parameter int unsigned ACC_W = dds_pkg::PHASE_W,
    parameter int unsigned CNT_W = dds_pkg::DIVCNT_W,
    parameter int unsigned SEL_W = dds_pkg::TAPSEL_W
) (
    input  logic             clk_fast,
    input  logic             clk_div,
    input  logic             rst,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [SEL_W-1:0] scale_sel,
    output logic             synth_msb,
    output logic             clk_out
);
    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i  (clk_fast),
        .rst_i  (rst),
        .tune_i (tune_word),
        .msb_o  (synth_msb)
    );

    dds_tap_div #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div (
        .clk_i (clk_div),
        .rst_i (rst),
        .sel_i (scale_sel),
        .out_o (clk_out)
    );
endmodule

// File: tb/tb_dds_clkgen.sv
`timescale 1ns/1ps
module tb_dds_clkgen;
    logic        clk_fast = 1'b0;
    logic        clk_div  = 1'b0;
    logic        rst      = 1'b1;
    logic [31:0] tune_word = '0;
    logic [4:0]  scale_sel = '0;
    logic        synth_msb, clk_out;

    int checks = 0;
    int errors = 0;
    bit mdl_en = 1'b0;
    bit done   = 1'b0;

    always #10 clk_fast = ~clk_fast;   // 50 MHz
    always #6  clk_div  = ~clk_div;

    dds_clkgen dut (
        .clk_fast (clk_fast), .clk_div (clk_div), .rst (rst),
        .tune_word (tune_word), .scale_sel (scale_sel),
        .synth_msb (synth_msb), .clk_out (clk_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // arithmetic model of the accumulator (R1)
    logic [31:0] m_acc, m_tune;
    always @(posedge clk_fast) begin
        if (rst) begin
            m_acc  <= '0;
            m_tune <= '0;
        end else begin
            m_acc  <= m_acc + m_tune;
            m_tune <= tune_word;
        end
    end

    always @(negedge clk_fast) begin
        if (mdl_en && !done)
            check(synth_msb == m_acc[31], "R1", "synth_msb vs model", synth_msb, m_acc[31]);
    end

    // measure np periods of synth_msb, rising edge to rising edge
    task automatic acc_scan(input int np, output int pmin, output int pmax,
                            output int hmin, output int hmax, output int n17);
        logic prev;
        int len, hc;
        pmin = 1000; pmax = 0; hmin = 1000; hmax = 0; n17 = 0;
        @(negedge clk_fast);
        prev = synth_msb;
        @(negedge clk_fast);
        while (!(prev == 1'b0 && synth_msb == 1'b1)) begin
            prev = synth_msb;
            @(negedge clk_fast);
        end
        for (int p = 0; p < np; p++) begin
            len = 0; hc = 0;
            do begin
                if (synth_msb) hc++;
                len++;
                prev = synth_msb;
                @(negedge clk_fast);
            end while (!(prev == 1'b0 && synth_msb == 1'b1));
            if (len < pmin) pmin = len;
            if (len > pmax) pmax = len;
            if (hc < hmin) hmin = hc;
            if (hc > hmax) hmax = hc;
            if (len == 17) n17++;
        end
    endtask

    // measure nr complete runs of clk_out; optionally change selector after run sw_at
    task automatic div_runs(input int nr, input int sw_at, input logic [4:0] new_sel,
                            output int runs[0:63]);
        logic prev, cur;
        int len;
        @(negedge clk_div);
        prev = clk_out;
        while (clk_out == prev) @(negedge clk_div);
        for (int r = 0; r < nr; r++) begin
            cur = clk_out;
            len = 0;
            while (clk_out == cur) begin
                len++;
                @(negedge clk_div);
            end
            runs[r] = len;
            if (r == sw_at - 1) scale_sel = new_sel;
        end
    endtask

    task automatic switch_test(input logic [4:0] from_sel, input logic [4:0] to_sel, input int nr);
        int runs[0:63];
        int lo, hi, old_after, first_new;
        bit bad_len, back_to_old;
        lo = 1 << from_sel;
        hi = 1 << to_sel;
        div_runs(nr, 3, to_sel, runs);
        for (int r = 0; r < 3; r++)
            check(runs[r] == lo, "R6", "run before switch", runs[r], lo);
        bad_len = 1'b0; back_to_old = 1'b0; old_after = 0; first_new = -1;
        for (int r = 3; r < nr; r++) begin
            if (runs[r] != lo && runs[r] != hi) bad_len = 1'b1;
            if (runs[r] == hi && first_new < 0) first_new = r;
            if (first_new >= 0 && runs[r] == lo) back_to_old = 1'b1;
            if (first_new < 0) old_after++;
        end
        check(!bad_len, "R6", "no runt run during switch", bad_len, 0);
        check(!back_to_old, "R6", "no return to old run length", back_to_old, 0);
        check(old_after <= 3, "R6", "old runs after change", old_after, 3);
        check(runs[nr-1] == hi, "R6", "final run length", runs[nr-1], hi);
    endtask

    initial begin
        int pmin, pmax, hmin, hmax, n17;
        int runs[0:63];
        logic [31:0] tw [0:5];
        // R7: reset state
        repeat (4) @(negedge clk_fast);
        check(synth_msb == 1'b0, "R7", "synth_msb in reset", synth_msb, 0);
        check(clk_out == 1'b0, "R7", "clk_out in reset", clk_out, 0);
        rst = 1'b0;
        mdl_en = 1'b1;

        // R1: irregular and extreme tuning words against the model
        tw[0] = 32'h0000_0000; tw[1] = 32'h8000_0000; tw[2] = 32'hFFFF_FFFF;
        tw[3] = 32'h1234_5679; tw[4] = 32'h3C00_0001; tw[5] = 32'h0FFF_FFEA;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_fast);
            tune_word = tw[i];
            repeat (150) @(negedge clk_fast);
        end

        // R2
        tune_word = 32'h1000_0000;
        acc_scan(40, pmin, pmax, hmin, hmax, n17);
        check(pmin == 16 && pmax == 16, "R2", "period min/max", pmax, 16);
        check(hmin == 8 && hmax == 8, "R2", "high cycles", hmax, 8);

        // R3
        tune_word = 32'h0800_0000;
        acc_scan(30, pmin, pmax, hmin, hmax, n17);
        check(pmin == 32 && pmax == 32, "R3", "period min/max", pmax, 32);
        check(hmin == 16 && hmax == 16, "R3", "high cycles", hmax, 16);

        // R4
        tune_word = 32'h0FE3_53F7;
        acc_scan(200, pmin, pmax, hmin, hmax, n17);
        check(pmin >= 16, "R4", "shortest period", pmin, 16);
        check(pmax <= 17, "R4", "longest period", pmax, 17);
        check(n17 >= 21 && n17 <= 24, "R4", "17-cycle periods in 200", n17, 22);

        // R5: every selector value 0..5
        for (int d = 0; d < 6; d++) begin
            @(negedge clk_div);
            scale_sel = 5'(d);
            repeat (160) @(negedge clk_div);
            div_runs(8, -1, 5'(d), runs);
            for (int r = 0; r < 8; r++)
                check(runs[r] == (1 << d), "R5", $sformatf("run length D=%0d", d), runs[r], 1 << d);
        end

        // R6: upward and downward switches
        @(negedge clk_div);
        scale_sel = 5'd2;
        repeat (160) @(negedge clk_div);
        switch_test(5'd2, 5'd4, 14);
        switch_test(5'd4, 5'd1, 24);

        // R7: reset in mid operation
        tune_word = 32'h4000_0000;
        repeat (20) @(negedge clk_fast);
        rst = 1'b1;
        repeat (3) @(negedge clk_fast);
        check(synth_msb == 1'b0, "R7", "synth_msb after mid reset", synth_msb, 0);
        check(clk_out == 1'b0, "R7", "clk_out after mid reset", clk_out, 0);
        rst = 1'b0;
        repeat (100) @(negedge clk_fast);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule